// File: doc/BRIEF.md
# Accelerator Start/Done Control Register Block

This block is the software-facing control and status register file of a compute accelerator. On one side is a plain 32-bit register-bus slave port: an address, a write strobe with write data, and a read strobe. Read data comes back registered, one cycle after the strobe. On the other side is the accelerator core's handshake. The block drives a launch request and a soft-reset request. It receives pulses when the core finishes a transaction, when it has consumed its inputs and when a soft reset has completed. It also receives an idle level.

Software starts a job by setting the launch bit, then learns the outcome by polling or by interrupt. The launch bit clears itself when the core finishes. The finish flag clears when the control word is read. The input-consumed flag drops when the finish event arrives. Two interrupt sources, finish and input-consumed, each pass through a per-source enable into a sticky status word. Software clears that word by writing ones to it. A master enable gates the single level interrupt output.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After reset every stored bit is 0, so bus_rdata, core_start, core_srst and irq are all 0.
- R2: The word index is bus_addr[3:2]: 0 is control, 1 is master enable, 2 is source enable and 3 is status. bus_addr[1:0] is ignored. Read data appears on bus_rdata in the cycle after bus_rd_en and holds until the next read. Unused bits read as 0.
- R3: Control bit 0 is launch. Writing 1 to it sets core_start, and writing 0 does not clear it. A core_done pulse clears it, unless that same cycle also writes 1 to it.
- R4: Control bit 1 is finish. A core_done pulse sets it. A read of the control word clears it, and that read returns the value held before the clear. If core_done arrives in the same cycle as such a read, the bit stays 1.
- R5: Control bit 2 returns the core_idle input as sampled at the read strobe.
- R6: Control bit 3 is input-consumed. A core_ready pulse sets it and a core_done pulse clears it. When both arrive in one cycle, the bit ends at 0.
- R7: Control bit 5 is soft reset and drives core_srst. Software writes it freely. It self-clears when core_srst_done is seen while it is set. That event sets control bit 6, the reset-complete flag, which clears only on a later write of 1 to bit 5.
- R8: Master enable is bit 0 of word 1. Source enables are bit 0 (finish) and bit 1 (input-consumed) of word 2. All three are read/write.
- R9: In word 3, bit 0 records core_done and bit 1 records core_ready. Each bit records its event only while its source enable is 1. Writing 1 to a bit clears it and writing 0 leaves it unchanged. An event in the same cycle as its clear leaves the bit at 1.
- R10: irq is 1 exactly when the master enable is 1 and at least one status bit is 1 while its source enable is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| core_start | output | 1 | Launch request to the core |
| core_srst | output | 1 | Soft-reset request to the core |
| core_done | input | 1 | Finish pulse from the core |
| core_idle | input | 1 | Core idle level |
| core_ready | input | 1 | Input-consumed pulse from the core |
| core_srst_done | input | 1 | Soft-reset-complete pulse from the core |
| irq | output | 1 | Level interrupt |

## Verification
The interrupt path is swept over every combination of master enable, the two source enables and the four finish/input-consumed event patterns. Each pattern is compared against an expected value computed arithmetically. The sweep separates a gate applied at recording time from one applied only at the output, and it catches swapped source bits. The launch, finish and input-consumed flags are driven through a normal job. They are then driven with colliding events: a finish pulse during the clearing read, finish and input-consumed together, and an event during its own write-one-to-clear. These collisions are what expose a wrong priority. The soft-reset sequence is repeated, with a zero write placed in between, to show which action clears the completion flag.

// File: rtl/accel_regs_pkg.sv
package accel_regs_pkg;
  localparam int WORD_CTRL = 0;
  localparam int WORD_GIE  = 1;
  localparam int WORD_IER  = 2;
  localparam int WORD_ISR  = 3;

  localparam int CB_START = 0;
  localparam int CB_DONE  = 1;
  localparam int CB_IDLE  = 2;
  localparam int CB_READY = 3;
  localparam int CB_SRST  = 5;
  localparam int CB_SDONE = 6;

  localparam int SRC_DONE  = 0;
  localparam int SRC_READY = 1;

  typedef struct packed {
    logic sdone;
    logic srst;
    logic ready;
    logic idle;
    logic done;
    logic start;
  } ctrl_view_t;
endpackage

// File: rtl/ar_handshake.sv
module ar_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wr_start1,
  input  logic wr_srst_val,
  input  logic rd_ctrl,
  input  logic core_done,
  input  logic core_ready,
  input  logic core_srst_done,
  output logic start_q,
  output logic done_q,
  output logic ready_q,
  output logic srst_q,
  output logic sdone_q
);
  logic start_d, done_d, ready_d, srst_d, sdone_d;
  logic start_en, done_en, ready_en, srst_en, sdone_en;
  logic srst_seen;

  assign srst_seen = srst_q & core_srst_done;

  always_comb begin
    start_en = (wr_ctrl & wr_start1) | core_done;
    start_d  = wr_ctrl & wr_start1;

    done_en  = rd_ctrl | core_done;
    done_d   = core_done;

    ready_en = core_ready | core_done;
    ready_d  = ~core_done;

    srst_en  = wr_ctrl | srst_seen;
    srst_d   = wr_ctrl ? wr_srst_val : 1'b0;

    sdone_en = (wr_ctrl & wr_srst_val) | srst_seen;
    sdone_d  = ~(wr_ctrl & wr_srst_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      ready_q <= 1'b0;
      srst_q  <= 1'b0;
      sdone_q <= 1'b0;
    end else begin
      if (start_en) start_q <= start_d;
      if (done_en)  done_q  <= done_d;
      if (ready_en) ready_q <= ready_d;
      if (srst_en)  srst_q  <= srst_d;
      if (sdone_en) sdone_q <= sdone_d;
    end
  end

  assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !(wr_ctrl && wr_start1)) |=> !start_q);
  assert_start_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_start1) |=> start_q);
  assert_done_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> done_q);
  assert_ready_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !ready_q);
  assert_srst_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && core_srst_done && !wr_ctrl) |=> (!srst_q && sdone_q));
endmodule

// File: rtl/ar_irq.sv
module ar_irq #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_gie,
  input  logic             wr_ier,
  input  logic             wr_isr,
  input  logic [N_SRC-1:0] wdata_src,
  input  logic [N_SRC-1:0] src_event,
  output logic             gie_q,
  output logic [N_SRC-1:0] ier_q,
  output logic [N_SRC-1:0] isr_q,
  output logic             irq
);
  logic gie_d;
  logic [N_SRC-1:0] ier_d;

  always_comb begin
    gie_d = wdata_src[0];
    ier_d = wdata_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      ier_q <= '0;
    end else begin
      if (wr_gie) gie_q <= gie_d;
      if (wr_ier) ier_q <= ier_d;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic rec, clr, en, d;
    always_comb begin
      rec = src_event[i] & ier_q[i];
      clr = wr_isr & wdata_src[i];
      en  = rec | clr;
      d   = rec;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  isr_q[i] <= 1'b0;
      else if (en) isr_q[i] <= d;
    end

    assert_isr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_q[i]) |-> $past(ier_q[i]));
    assert_isr_setwins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (src_event[i] && ier_q[i]) |=> isr_q[i]);
  end

  assign irq = gie_q & (|(ier_q & isr_q));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie_q);
endmodule

// File: rtl/ar_readmux.sv
module ar_readmux #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              hit,
  input  logic [1:0]        word_sel,
  input  logic [DATA_W-1:0] w_ctrl,
  input  logic [DATA_W-1:0] w_gie,
  input  logic [DATA_W-1:0] w_ier,
  input  logic [DATA_W-1:0] w_isr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel_d;

  always_comb begin
    sel_d = '0;
    if (hit) begin
      unique case (word_sel)
        2'd0: sel_d = w_ctrl;
        2'd1: sel_d = w_gie;
        2'd2: sel_d = w_ier;
        default: sel_d = w_isr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel_d;
  end

  assert_rd_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[DATA_W-1:7] == '0) && !rdata[4]);
  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
  import accel_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_start,
  output logic              core_srst,
  input  logic              core_done,
  input  logic              core_idle,
  input  logic              core_ready,
  input  logic              core_srst_done,
  output logic              irq
);
  localparam int N_SRC = 2;

  logic       hit;
  logic [1:0] word_sel;
  logic       wr_ctrl, wr_gie, wr_ier, wr_isr, rd_ctrl;

  if (ADDR_W > 4) begin : g_hi
    assign hit = ~|bus_addr[ADDR_W-1:4];
  end else begin : g_nohi
    assign hit = 1'b1;
  end
  assign word_sel = bus_addr[3:2];

  always_comb begin
    wr_ctrl = bus_wr_en & hit & (word_sel == 2'(WORD_CTRL));
    wr_gie  = bus_wr_en & hit & (word_sel == 2'(WORD_GIE));
    wr_ier  = bus_wr_en & hit & (word_sel == 2'(WORD_IER));
    wr_isr  = bus_wr_en & hit & (word_sel == 2'(WORD_ISR));
    rd_ctrl = bus_rd_en & hit & (word_sel == 2'(WORD_CTRL));
  end

  ctrl_view_t       cv;
  logic             gie_q;
  logic [N_SRC-1:0] ier_q, isr_q, src_event;

  ar_handshake u_hs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_ctrl),
    .wr_start1(bus_wdata[CB_START]),
    .wr_srst_val(bus_wdata[CB_SRST]),
    .rd_ctrl(rd_ctrl),
    .core_done(core_done), .core_ready(core_ready),
    .core_srst_done(core_srst_done),
    .start_q(cv.start), .done_q(cv.done), .ready_q(cv.ready),
    .srst_q(cv.srst), .sdone_q(cv.sdone)
  );
  assign cv.idle = core_idle;

  assign src_event[SRC_DONE]  = core_done;
  assign src_event[SRC_READY] = core_ready;

  ar_irq #(.N_SRC(N_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_gie(wr_gie), .wr_ier(wr_ier), .wr_isr(wr_isr),
    .wdata_src(bus_wdata[N_SRC-1:0]),
    .src_event(src_event),
    .gie_q(gie_q), .ier_q(ier_q), .isr_q(isr_q), .irq(irq)
  );

  logic [DATA_W-1:0] w_ctrl, w_gie, w_ier, w_isr;
  always_comb begin
    w_ctrl = '0;
    w_ctrl[CB_START] = cv.start;
    w_ctrl[CB_DONE]  = cv.done;
    w_ctrl[CB_IDLE]  = cv.idle;
    w_ctrl[CB_READY] = cv.ready;
    w_ctrl[CB_SRST]  = cv.srst;
    w_ctrl[CB_SDONE] = cv.sdone;
    w_gie = '0;
    w_gie[0] = gie_q;
    w_ier = '0;
    w_ier[N_SRC-1:0] = ier_q;
    w_isr = '0;
    w_isr[N_SRC-1:0] = isr_q;
  end

  ar_readmux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_en(bus_rd_en), .hit(hit), .word_sel(word_sel),
    .w_ctrl(w_ctrl), .w_gie(w_gie), .w_ier(w_ier), .w_isr(w_isr),
    .rdata(bus_rdata)
  );

  assign core_start = cv.start;
  assign core_srst  = cv.srst;

  assert_done_rdclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !core_done) |=> !cv.done);
endmodule

// File: tb/accel_ctrl_regs_test.sv
module accel_ctrl_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_wr_en = 0;
  logic [31:0] bus_wdata = 0;
  logic        bus_rd_en = 0;
  logic [31:0] bus_rdata;
  logic        core_start, core_srst, irq;
  logic        core_done = 0, core_idle = 1, core_ready = 0, core_srst_done = 0;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  accel_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .core_start(core_start), .core_srst(core_srst), .core_done(core_done),
    .core_idle(core_idle), .core_ready(core_ready),
    .core_srst_done(core_srst_done), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1;
    @(posedge clk); #1;
    bus_wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1;
    @(posedge clk); #1;
    bus_rd_en = 0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic dn, input logic rdy, input logic sd);
    @(negedge clk);
    core_done = dn; core_ready = rdy; core_srst_done = sd;
    @(posedge clk); #1;
    core_done = 0; core_ready = 0; core_srst_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 start/srst/irq", {core_start, core_srst, irq}, 0);
    @(negedge clk); rst_n = 1;
    rd(4'h0, d); chk("R1 ctrl after reset", d, 32'h4);
    rd(4'hC, d); chk("R1 isr after reset", d, 0);
    // R5 idle mirror
    core_idle = 0; rd(4'h0, d); chk("R5 idle low", d, 0);
    core_idle = 1; rd(4'h0, d); chk("R5 idle high", d, 32'h4);
    // R3 launch
    wr(4'h0, 32'h0000_0001); chk("R3 core_start set", core_start, 1);
    wr(4'h0, 32'h0000_0000); chk("R3 write 0 keeps start", core_start, 1);
    rd(4'h0, d); chk("R3 ctrl start", d, 32'h5);
    pulse(0, 1, 0); rd(4'h0, d); chk("R6 ready set", d, 32'hD);
    pulse(1, 0, 0); chk("R3 start cleared by done", core_start, 0);
    rd(4'h0, d); chk("R4 done set, R6 ready cleared", d, 32'h6);
    rd(4'h0, d); chk("R4 done cleared by read", d, 32'h4);
    // R4 done coinciding with a clearing read
    @(negedge clk);
    bus_addr = 0; bus_rd_en = 1; core_done = 1;
    @(posedge clk); #1;
    bus_rd_en = 0; core_done = 0;
    chk("R4 coincident read sees old", bus_rdata, 32'h4);
    rd(4'h0, d); chk("R4 coincident keeps done", d, 32'h6);
    // R6 ready and done together
    pulse(1, 1, 0); rd(4'h0, d); chk("R6 done beats ready", d, 32'h6);
    // R7 soft reset
    wr(4'h0, 32'h20); chk("R7 core_srst set", core_srst, 1);
    rd(4'h0, d); chk("R7 ctrl srst", d, 32'h24);
    pulse(0, 0, 1); chk("R7 srst self-clear", core_srst, 0);
    rd(4'h0, d); chk("R7 sdone set", d, 32'h44);
    wr(4'h0, 32'h0); rd(4'h0, d); chk("R7 write 0 keeps sdone", d, 32'h44);
    wr(4'h0, 32'h20); rd(4'h0, d); chk("R7 write 1 clears sdone", d, 32'h24);
    pulse(0, 0, 1); rd(4'h0, d); chk("R7 second sdone", d, 32'h44);
    // R8 enable registers, R2 ignored low bits
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, d); chk("R8 gie", d, 32'h1);
    rd(4'h5, d); chk("R2 low addr bits ignored", d, 32'h1);
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, d); chk("R8 ier", d, 32'h3);
    wr(4'h8, 32'h0); rd(4'h8, d); chk("R8 ier cleared", d, 32'h0);
    @(negedge clk); chk("R2 rdata held", bus_rdata, 32'h0);
    // R9/R10 sweep
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 4; e++)
        for (int ev = 0; ev < 4; ev++) begin
          logic [1:0] exp_isr;
          wr(4'h8, 32'h0);
          wr(4'hC, 32'h3);
          wr(4'h4, 32'(g));
          wr(4'h8, 32'(e));
          pulse(ev[0], ev[1], 0);
          exp_isr = 2'(ev) & 2'(e);
          rd(4'hC, d); chk($sformatf("R9 isr g%0d e%0d ev%0d", g, e, ev), d, 32'(exp_isr));
          chk($sformatf("R10 irq g%0d e%0d ev%0d", g, e, ev), irq, 32'(g != 0 && exp_isr != 0));
          wr(4'h8, 32'h3);
          chk($sformatf("R9 late enable no irq g%0d e%0d ev%0d", g, e, ev),
              irq, 32'(g != 0 && exp_isr != 0));
        end
    // R9 set wins over clear, W1C per bit
    wr(4'hC, 32'h3); wr(4'h4, 32'h1); wr(4'h8, 32'h3);
    pulse(1, 0, 0); chk("R10 irq on done", irq, 1);
    @(negedge clk);
    bus_addr = 4'hC; bus_wdata = 32'h1; bus_wr_en = 1; core_done = 1;
    @(posedge clk); #1;
    bus_wr_en = 0; core_done = 0;
    rd(4'hC, d); chk("R9 set beats clear", d, 32'h1);
    wr(4'hC, 32'h2); rd(4'hC, d); chk("R9 write 1 to other bit only", d, 32'h1);
    wr(4'hC, 32'h0); rd(4'hC, d); chk("R9 write 0 no effect", d, 32'h1);
    wr(4'hC, 32'h1); rd(4'hC, d); chk("R9 cleared", d, 32'h0);
    chk("R10 irq low after clear", irq, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule